// File: doc/BRIEF.md
# Two-Port DMA Transfer Engine

This engine copies a block of bytes from a source port to a destination port on a simple synchronous bus. It also scans bytes against a pattern. Each port keeps its own address counter. That counter can stay fixed, count up or count down. A per-port flag marks the port as memory or I/O, so any pairing of the two kinds is possible. A masked compare runs on every byte read. The job can be a copy only, a scan only, or a scan that also copies.

Software sets the engine up through a small register-write interface, then starts it with a command write. The engine arbitrates for the bus with a request/grant pair. It uses one of three request policies. Byte mode gives the bus back after each byte. Burst mode keeps the bus while the peripheral's ready line stays high. Continuous mode keeps the bus until the block is done. The starting addresses and length sit in buffer registers. Software can rewrite them while a job runs without affecting that job. With auto-restart set, the engine reloads the buffers when the count runs out and starts the same sequence again.

Register map (`cfg_addr`): 0 source start, 1 destination start, 2 length, 3 control, 4 pattern, 5 command (bit 0 = start).

Control word bits:
- [1:0] operation: 0 or 1 copy, 2 scan only, 3 scan and copy.
- [3:2] request policy: 0 byte, 1 burst, 2 continuous, 3 behaves as byte.
- [5:4] source step and [7:6] destination step: 0 fixed, 1 up, 2 down, 3 fixed.
- [8] source is I/O.
- [9] destination is I/O.
- [10] auto-restart.

Pattern word: [7:0] compare value, [15:8] don't-care mask.

Top module: `dma_engine`

## Requirements
- R1: A write of 1 to bit 0 of register 5 while idle loads the buffered addresses and length and raises `busy` in the next cycle.
- R2: Each copied byte is one read at the source address, with `bus_io` equal to control bit 8. It is followed by one write of that same byte at the destination address, with `bus_io` equal to control bit 9. Bytes go in order.
- R3: After each byte, the source address and the destination address each move according to their own 2-bit step field: fixed (0), +1 (1) or -1 (2).
- R4: In byte mode (policy 0), `bus_req` drops for at least one cycle after each byte.
- R5: In burst mode (policy 1), `bus_req` stays high from byte to byte while `dev_rdy` is high. It drops when `dev_rdy` is low at the end of a byte.
- R6: In continuous mode (policy 2), once `bus_req` rises during a job it stays high until `busy` falls, even when `dev_rdy` goes low.
- R7: `bus_rd` and `bus_wr` are only asserted while both `bus_req` and `bus_gnt` are high, and never together.
- R8: A byte matches when it equals pattern bits [7:0] on every bit whose pattern mask bit [15:8] is 0.
- R9: In scan-only mode (operation 2) there are no writes. A matching byte ends the job with `match_found` set, `end_of_block` clear, and `count_left` holding the bytes not yet scanned.
- R10: When the last byte completes without a match and auto-restart is off, `end_of_block` is set, `busy` falls and `count_left` is 0.
- R11: Writes to the start-address registers during a job do not change the addresses that job uses.
- R12: With auto-restart on, reaching count zero reloads the buffered addresses and length and continues without setting `end_of_block` or dropping `busy`.
- R13: Starting with a length of 0 sets `end_of_block` at once, leaves `busy` low and makes no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | RW | Register write data |
| dev_rdy | input | 1 | Peripheral ready for the next byte |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Access address |
| bus_io | output | 1 | Access targets I/O space (1) or memory (0) |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ack | input | 1 | Access complete |
| busy | output | 1 | Job in progress |
| match_found | output | 1 | Last job stopped on a match |
| end_of_block | output | 1 | Last job ran out its count |
| count_left | output | CW | Bytes remaining |

## Verification
The copy path is run in three ways: memory to memory with both addresses counting up, memory to a fixed I/O port with the source counting down, and I/O to I/O with opposite steps. A swapped step direction or a wrong space flag therefore shows up as a wrong entry in the recorded access list. The three request policies are told apart by counting `bus_req` rising edges. A steady ready line separates byte mode from the other two. A ready line pulled low for a few cycles after a chosen byte separates burst from continuous. Scanning uses data where the only matching byte differs from the value in masked bits only, and earlier bytes differ in unmasked bits. This catches an inverted mask. A restart run rewrites the source buffer mid-job, which shows both that the live job ignores the write and that the reload picks it up.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int CFG_AW = 3;
  localparam logic [CFG_AW-1:0] RA_SRC  = 3'd0;
  localparam logic [CFG_AW-1:0] RA_DST  = 3'd1;
  localparam logic [CFG_AW-1:0] RA_LEN  = 3'd2;
  localparam logic [CFG_AW-1:0] RA_CTRL = 3'd3;
  localparam logic [CFG_AW-1:0] RA_PAT  = 3'd4;
  localparam logic [CFG_AW-1:0] RA_CMD  = 3'd5;

  typedef enum logic [1:0] {STEP_HOLD = 2'd0, STEP_UP = 2'd1, STEP_DOWN = 2'd2, STEP_RSVD = 2'd3} dma_step_e;
  typedef enum logic [1:0] {REL_BYTE = 2'd0, REL_BURST = 2'd1, REL_CONT = 2'd2, REL_RSVD = 2'd3} dma_rel_e;
  typedef enum logic [1:0] {OP_COPY0 = 2'd0, OP_COPY = 2'd1, OP_SCAN = 2'd2, OP_SCAN_COPY = 2'd3} dma_op_e;

  typedef struct packed {
    logic      restart;
    logic      dst_io;
    logic      src_io;
    dma_step_e dst_step;
    dma_step_e src_step;
    dma_rel_e  rel;
    dma_op_e   op;
  } dma_ctrl_t;

  localparam int CTRL_W = $bits(dma_ctrl_t);

  typedef enum logic [2:0] {ST_IDLE, ST_ARB, ST_RD, ST_WR, ST_NEXT, ST_REL} dma_state_e;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  dma_step_e     mode,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] UNIT = AW'(1);
  logic [AW-1:0] addr_n;

  always_comb begin
    addr_n = addr;
    if (load) begin
      addr_n = base;
    end else if (step) begin
      case (mode)
        STEP_UP:   addr_n = addr + UNIT;
        STEP_DOWN: addr_n = addr - UNIT;
        default:   addr_n = addr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             addr <= '0;
    else if (load || step)  addr <= addr_n;
  end
endmodule

// File: rtl/dma_match.sv
module dma_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] mask,
  output logic          hit
);
  assign hit = ((data ^ value) & ~mask) == '0;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int RW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [RW-1:0]     cfg_wdata,
  input  logic              dev_rdy,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_io,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ack,
  output logic              busy,
  output logic              match_found,
  output logic              end_of_block,
  output logic [CW-1:0]     count_left
);
  localparam int NPORT = 2;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic core_rst_n;
  dma_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(core_rst_n));

  // configuration buffers
  logic [AW-1:0] src_buf, dst_buf;
  logic [CW-1:0] len_buf;
  dma_ctrl_t     ctrl_q;
  logic [DW-1:0] pat_val, pat_mask;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      src_buf  <= '0;
      dst_buf  <= '0;
      len_buf  <= '0;
      ctrl_q   <= '0;
      pat_val  <= '0;
      pat_mask <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RA_SRC:  src_buf <= cfg_wdata[AW-1:0];
        RA_DST:  dst_buf <= cfg_wdata[AW-1:0];
        RA_LEN:  len_buf <= cfg_wdata[CW-1:0];
        RA_CTRL: ctrl_q  <= dma_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        RA_PAT: begin
          pat_val  <= cfg_wdata[DW-1:0];
          pat_mask <= cfg_wdata[2*DW-1:DW];
        end
        default: ;
      endcase
    end
  end

  // working state
  dma_state_e    state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [DW-1:0] data_q, data_n;
  logic          match_q, match_n, eob_q, eob_n;
  logic          load_ptrs;
  logic          start_cmd, do_copy, do_scan, byte_hit;

  // per-port address counters
  logic [AW-1:0] port_base [NPORT];
  logic [AW-1:0] port_addr [NPORT];
  dma_step_e     port_mode [NPORT];
  logic [NPORT-1:0] port_step;

  assign port_base[0] = src_buf;
  assign port_base[1] = dst_buf;
  assign port_mode[0] = ctrl_q.src_step;
  assign port_mode[1] = ctrl_q.dst_step;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      dma_addr_ctr #(.AW(AW)) u_ctr (
        .clk   (clk),
        .rst_n (core_rst_n),
        .load  (load_ptrs),
        .step  (port_step[p]),
        .mode  (port_mode[p]),
        .base  (port_base[p]),
        .addr  (port_addr[p])
      );
    end
  endgenerate

  dma_match #(.DW(DW)) u_match (.data(data_q), .value(pat_val), .mask(pat_mask), .hit(byte_hit));

  assign start_cmd = cfg_we && (cfg_addr == RA_CMD) && cfg_wdata[0] && (state == ST_IDLE);
  assign do_copy   = (ctrl_q.op != OP_SCAN);
  assign do_scan   = ctrl_q.op[1];

  // next-state logic
  always_comb begin
    dma_state_e cont_st;
    state_n   = state;
    cnt_n     = cnt;
    data_n    = data_q;
    match_n   = match_q;
    eob_n     = eob_q;
    load_ptrs = 1'b0;
    port_step = '0;
    bus_req   = 1'b0;
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_io    = 1'b0;
    bus_wdata = data_q;

    case (ctrl_q.rel)
      REL_BURST: cont_st = (dev_rdy && bus_gnt) ? ST_RD : ST_REL;
      REL_CONT:  cont_st = (dev_rdy && bus_gnt) ? ST_RD : ST_ARB;
      default:   cont_st = ST_REL;
    endcase

    case (state)
      ST_IDLE: begin
        if (start_cmd) begin
          match_n = 1'b0;
          if (len_buf == '0) begin
            eob_n = 1'b1;
          end else begin
            eob_n     = 1'b0;
            load_ptrs = 1'b1;
            cnt_n     = len_buf;
            state_n   = ST_ARB;
          end
        end
      end
      ST_ARB: begin
        bus_req = dev_rdy || (ctrl_q.rel == REL_CONT);
        if (bus_req && bus_gnt && dev_rdy) state_n = ST_RD;
      end
      ST_RD: begin
        bus_req  = 1'b1;
        bus_rd   = 1'b1;
        bus_addr = port_addr[0];
        bus_io   = ctrl_q.src_io;
        if (bus_ack) begin
          data_n  = bus_rdata;
          state_n = do_copy ? ST_WR : ST_NEXT;
        end
      end
      ST_WR: begin
        bus_req  = 1'b1;
        bus_wr   = 1'b1;
        bus_addr = port_addr[1];
        bus_io   = ctrl_q.dst_io;
        if (bus_ack) state_n = ST_NEXT;
      end
      ST_NEXT: begin
        bus_req      = 1'b1;
        port_step[0] = 1'b1;
        port_step[1] = do_copy;
        cnt_n        = cnt - CNT_ONE;
        if (do_scan && byte_hit) begin
          match_n = 1'b1;
          state_n = ST_IDLE;
        end else if (cnt == CNT_ONE) begin
          if (ctrl_q.restart) begin
            load_ptrs = 1'b1;
            cnt_n     = len_buf;
            state_n   = cont_st;
          end else begin
            eob_n   = 1'b1;
            state_n = ST_IDLE;
          end
        end else begin
          state_n = cont_st;
        end
      end
      ST_REL:  state_n = ST_ARB;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      data_q  <= '0;
      match_q <= 1'b0;
      eob_q   <= 1'b0;
    end else begin
      state   <= state_n;
      cnt     <= cnt_n;
      data_q  <= data_n;
      match_q <= match_n;
      eob_q   <= eob_n;
    end
  end

  assign busy         = (state != ST_IDLE);
  assign match_found  = match_q;
  assign end_of_block = eob_q;
  assign count_left   = cnt;

  // assertions
  p_strobe_granted_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_rd || bus_wr) |-> (bus_req && bus_gnt));
  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(bus_rd && bus_wr));
  p_scan_no_write_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ctrl_q.op == OP_SCAN) |-> !bus_wr);
  p_match_ends_job_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(match_found) |-> !busy);
  p_eob_idle_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(end_of_block) |-> !busy);
  p_cont_holds_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (busy && bus_req && ctrl_q.rel == REL_CONT) |=> (bus_req || !busy || ctrl_q.rel != REL_CONT));
  p_byte_gap_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($fell(bus_wr) && ctrl_q.rel == REL_BYTE) |=> !bus_req);
endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;
  localparam int AW = 16, CW = 16, DW = 8, RW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_addr;
  logic [RW-1:0] cfg_wdata;
  logic          dev_rdy = 1'b1;
  logic          bus_req, bus_gnt = 1'b0;
  logic [AW-1:0] bus_addr;
  logic          bus_io, bus_rd, bus_wr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic          bus_ack = 1'b0;
  logic          busy, match_found, end_of_block;
  logic [CW-1:0] count_left;

  always #2 clk = ~clk;

  dma_engine #(.AW(AW), .CW(CW), .DW(DW), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dev_rdy(dev_rdy), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_io(bus_io), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .busy(busy), .match_found(match_found),
    .end_of_block(end_of_block), .count_left(count_left)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0]  mem [256];
  logic [7:0]  iom [256];
  logic [25:0] log_q[$], exp_q[$];
  int  req_rises = 0, proto_err = 0, bytes_done = 0, pause_at = -1, pause_cnt = 0;
  bit  req_prev = 1'b0, scan_only_tb = 1'b0, rdy_en = 1'b1, byte_end;
  logic [7:0] rd_byte;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus model and per-clock protocol watch (R7), sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if ((bus_rd || bus_wr) && !(bus_req && bus_gnt)) proto_err++;
      if (bus_rd && bus_wr) proto_err++;
      if (busy && bus_req && !req_prev) req_rises++;
    end
    req_prev = bus_req;
    if (pause_cnt > 0) pause_cnt--;
    byte_end = 1'b0;
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_rd || bus_wr) begin
      bus_ack = 1'b1;
      if (bus_rd) begin
        rd_byte   = bus_io ? iom[bus_addr[7:0]] : mem[bus_addr[7:0]];
        bus_rdata = rd_byte;
        log_q.push_back({1'b0, bus_io, bus_addr, rd_byte});
        if (scan_only_tb) byte_end = 1'b1;
      end else begin
        if (bus_io) iom[bus_addr[7:0]] = bus_wdata;
        else        mem[bus_addr[7:0]] = bus_wdata;
        log_q.push_back({1'b1, bus_io, bus_addr, bus_wdata});
        byte_end = 1'b1;
      end
      if (byte_end) begin
        bytes_done++;
        if (bytes_done == pause_at) pause_cnt = 3;
      end
    end
    dev_rdy = rdy_en && (pause_cnt == 0);
    bus_gnt = bus_req;
  end

  task automatic cfg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] mk_ctrl(input logic [1:0] op, rel, ss, ds, input bit sio, dio, rs);
    return {5'd0, rs, dio, sio, ds, ss, rel, op};
  endfunction

  function automatic logic [15:0] stepf(input logic [15:0] a, input logic [1:0] m);
    return (m == 2'd1) ? a + 16'd1 : (m == 2'd2) ? a - 16'd1 : a;
  endfunction

  // reference sequence of bus accesses, computed from the requirements
  task automatic plan(input logic [15:0] src, dst, input int n, input logic [1:0] ss, ds,
                      input bit sio, dio, input logic [1:0] op, input logic [7:0] val, msk,
                      output int used, output bit hit);
    logic [15:0] s = src, d = dst;
    logic [7:0] b;
    hit = 1'b0; used = n;
    for (int i = 0; i < n; i++) begin
      b = sio ? iom[s[7:0]] : mem[s[7:0]];
      exp_q.push_back({1'b0, sio, s, b});
      if (op != 2'd2) exp_q.push_back({1'b1, dio, d, b});
      if (op[1] && (((b ^ val) & ~msk) == 8'h00)) begin
        hit = 1'b1; used = i + 1;
        break;
      end
      s = stepf(s, ss);
      if (op != 2'd2) d = stepf(d, ds);
    end
  endtask

  task automatic cmp_log(input string req);
    int bad = -1;
    if (log_q.size() != exp_q.size()) bad = 0;
    for (int i = 0; i < log_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s access list (size %0d vs %0d) entry %0d: actual=%0h expected=%0h", req,
               log_q.size(), exp_q.size(), bad,
               (bad < log_q.size()) ? log_q[bad] : 26'h0, (bad < exp_q.size()) ? exp_q[bad] : 26'h0);
    end
  endtask

  task automatic prep(input bit scan, input int pause);
    log_q.delete(); exp_q.delete();
    req_rises = 0; bytes_done = 0; pause_at = pause; scan_only_tb = scan;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] src, dst, len, ctrl);
    cfg(3'd0, src); cfg(3'd1, dst); cfg(3'd2, len); cfg(3'd3, ctrl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int used;
    bit hit;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      iom[i] = 8'hC0 ^ 8'(i);
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R1, R10)
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "bus_req after reset", bus_req, 0);
    chk("R10", "eob after reset", end_of_block, 0);
    chk("R10", "count after reset", count_left, 0);

    // A: mem->mem, both up, byte mode
    prep(0, -1);
    setup(16'h0010, 16'h0080, 16'd4, mk_ctrl(2'd1, 2'd0, 2'd1, 2'd1, 0, 0, 0));
    plan(16'h0010, 16'h0080, 4, 2'd1, 2'd1, 0, 0, 2'd1, 8'h00, 8'h00, used, hit);
    cfg(3'd5, 16'h0001);
    chk("R1", "busy after start", busy, 1);
    wait_idle();
    cmp_log("R2");
    chk("R4", "request rises in byte mode", req_rises, 4);
    chk("R10", "eob", end_of_block, 1);
    chk("R10", "count at end", count_left, 0);
    chk("R10", "match flag", match_found, 0);

    // B: mem down -> fixed I/O, burst, steady ready
    prep(0, -1);
    setup(16'h0030, 16'h0005, 16'd3, mk_ctrl(2'd1, 2'd1, 2'd2, 2'd0, 0, 1, 0));
    plan(16'h0030, 16'h0005, 3, 2'd2, 2'd0, 0, 1, 2'd1, 8'h00, 8'h00, used, hit);
    cfg(3'd5, 16'h0001);
    wait_idle();
    cmp_log("R3");
    chk("R5", "burst rises, steady ready", req_rises, 1);

    // C: burst with ready dropped after byte 1
    prep(0, 1);
    setup(16'h0040, 16'h0010, 16'd3, mk_ctrl(2'd1, 2'd1, 2'd1, 2'd1, 0, 1, 0));
    plan(16'h0040, 16'h0010, 3, 2'd1, 2'd1, 0, 1, 2'd1, 8'h00, 8'h00, used, hit);
    cfg(3'd5, 16'h0001);
    wait_idle();
    cmp_log("R5");
    chk("R5", "burst rises, ready gap", req_rises, 2);

    // D: continuous, I/O up -> I/O down, ready dropped after byte 2
    prep(0, 2);
    setup(16'h0020, 16'h0060, 16'd4, mk_ctrl(2'd1, 2'd2, 2'd1, 2'd2, 1, 1, 0));
    plan(16'h0020, 16'h0060, 4, 2'd1, 2'd2, 1, 1, 2'd1, 8'h00, 8'h00, used, hit);
    cfg(3'd5, 16'h0001);
    wait_idle();
    cmp_log("R6");
    chk("R6", "continuous rises, ready gap", req_rises, 1);

    // E: scan only, value A5 mask 0F; third byte A3 matches under mask
    mem[8'h90] = 8'h35; mem[8'h91] = 8'h5A; mem[8'h92] = 8'hA3; mem[8'h93] = 8'hA5; mem[8'h94] = 8'h00;
    prep(1, -1);
    cfg(3'd4, 16'h0FA5);
    setup(16'h0090, 16'h00F0, 16'd5, mk_ctrl(2'd2, 2'd1, 2'd1, 2'd1, 0, 0, 0));
    plan(16'h0090, 16'h00F0, 5, 2'd1, 2'd1, 0, 0, 2'd2, 8'hA5, 8'h0F, used, hit);
    cfg(3'd5, 16'h0001);
    wait_idle();
    cmp_log("R9");
    chk("R8", "masked match", match_found, 1);
    chk("R9", "eob on match", end_of_block, 0);
    chk("R9", "count left on match", count_left, 5 - used);

    // G: zero length
    prep(0, -1);
    setup(16'h0010, 16'h0080, 16'd0, mk_ctrl(2'd1, 2'd0, 2'd1, 2'd1, 0, 0, 0));
    cfg(3'd5, 16'h0001);
    @(negedge clk);
    chk("R13", "busy with zero length", busy, 0);
    chk("R13", "eob with zero length", end_of_block, 1);
    chk("R13", "bus activity", req_rises + log_q.size(), 0);

    // F: scan and copy, no byte matches
    prep(0, -1);
    cfg(3'd4, 16'h0011);
    setup(16'h0090, 16'h00B0, 16'd3, mk_ctrl(2'd3, 2'd1, 2'd1, 2'd1, 0, 0, 0));
    plan(16'h0090, 16'h00B0, 3, 2'd1, 2'd1, 0, 0, 2'd3, 8'h11, 8'h00, used, hit);
    cfg(3'd5, 16'h0001);
    wait_idle();
    cmp_log("R8");
    chk("R8", "no match", match_found, 0);
    chk("R10", "eob after scan-copy", end_of_block, 1);

    // H: auto-restart; source buffer rewritten during the first pass
    prep(0, -1);
    setup(16'h0010, 16'h00C0, 16'd2, mk_ctrl(2'd1, 2'd0, 2'd1, 2'd1, 0, 0, 1));
    plan(16'h0010, 16'h00C0, 2, 2'd1, 2'd1, 0, 0, 2'd1, 8'h00, 8'h00, used, hit);
    plan(16'h0050, 16'h00C0, 2, 2'd1, 2'd1, 0, 0, 2'd1, 8'h00, 8'h00, used, hit);
    cfg(3'd5, 16'h0001);
    cfg(3'd0, 16'h0050);
    while (log_q.size() < 4) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R12", "busy across reload", busy, 1);
    chk("R12", "eob across reload", end_of_block, 0);
    cfg(3'd3, mk_ctrl(2'd1, 2'd0, 2'd1, 2'd1, 0, 0, 0));
    wait_idle();
    chk("R11", "second read of first pass", (log_q.size() > 2) ? log_q[2][23:8] : 16'hFFFF, 16'h0011);
    cmp_log("R12");
    chk("R12", "eob after final pass", end_of_block, 1);

    chk("R7", "strobe protocol errors", proto_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule